// File: doc/BRIEF.md
# SDRAM Bank State and Power-Mode Tracker

This block sits on the command side of a four-bank double-data-rate SDRAM model. On every rising clock edge it samples the registered command pins (chip select, row strobe, column strobe and write enable), the bank address, address bit 10 and clock enable. From these it maintains an open or idle flag for every bank. It also decides which low-power state the device is in once clock enable is taken low.

It also emits a one-cycle strobe when a mode register is written and says which of the two registers was addressed. A sticky error flag reports protocol misuse: an activate to an already-open bank, an access to an idle bank, or clock enable dropped during a read or write. A verification environment or a memory model uses it to follow the state a real device would be in, with no data path attached.

Top module: `ddr_bank_tracker`

## Requirements
- R1: While cs_n is sampled high, the command is ignored: bank_open does not change, no mode-register strobe is produced and no error is raised.
- R2: Commands are active-low on {ras_n,cas_n,we_n} with cs_n low: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register write, 111 no-op. An accepted activate sets bank_open[ba] in the cycle after the edge.
- R3: An accepted precharge with a10 low clears only bank_open[ba]. With a10 high it clears every bank.
- R4: An accepted activate to an open bank, or an accepted read or write to an idle bank, sets err and leaves bank_open unchanged.
- R5: An accepted mode-register write with ba=0 pulses mrs_wr for one cycle with mrs_sel=0 (base register). With ba=1 it pulses with mrs_sel=1 (extended register). With ba of 2 or 3 it gives no pulse. mrs_sel holds its value between pulses and resets to 0.
- R6: In normal mode (pwr_mode=0), clock enable sampled low moves pwr_mode to 1 (precharge power-down) when all banks are idle, or to 2 (active power-down) when any bank is open. Any command on that edge other than a qualifying refresh is ignored.
- R7: A refresh with cs_n low, sampled together with clock enable low while all banks are idle, moves pwr_mode to 3 (self refresh).
- R8: In modes 1, 2 and 3, commands are ignored. The mode changes back to 0 on the first edge that samples clock enable high, and the command on that edge is also ignored.
- R9: In self refresh, pwr_mode reads 0 as soon as cke is high, without waiting for a clock edge. Modes 1 and 2 are left only at an edge.
- R10: A read or write presented in normal mode while clock enable is low sets err.
- R11: Asserting rst_n low at once clears bank_open, pwr_mode, mrs_wr, mrs_sel and err.
- R12: Once set, err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low; high masks the command |
| ras_n | input | 1 | Row strobe command bit, active low |
| cas_n | input | 1 | Column strobe command bit, active low |
| we_n | input | 1 | Write-enable command bit, active low |
| ba | input | 2 | Bank address; selects the mode register on a mode-register write |
| a10 | input | 1 | Precharge scope: 0 one bank, 1 all banks |
| cke | input | 1 | Clock enable |
| bank_open | output | 4 | One flag per bank, 1 when a row is open |
| pwr_mode | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| mrs_wr | output | 1 | One-cycle mode-register write strobe |
| mrs_sel | output | 1 | Register addressed by the last strobe: 0 base, 1 extended |
| err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its default of four banks, which gives two bank-address bits. With that setting the whole single-edge input space is small. For each of the 16 open-bank patterns it applies all 256 combinations of clock enable, a10, bank address, chip select and the three command bits, then a recovery edge. This covers every transition out of normal mode and every exit from the power-down modes. A long pseudo-random run with periodic resets then drives multi-step sequences through the power modes. Every output is compared on every cycle against an arithmetic model written from the requirements.

// File: rtl/bktrk_pkg.sv
package bktrk_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'd0,
    PM_PRE_PD   = 2'd1,
    PM_ACT_PD   = 2'd2,
    PM_SELF_REF = 2'd3
  } pmode_e;

endpackage

// File: rtl/bktrk_cmd_decode.sv
module bktrk_cmd_decode
  import bktrk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/bktrk_power_fsm.sv
module bktrk_power_fsm
  import bktrk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  cmd_e       cmd,
  input  logic       any_open,
  output pmode_e     mode_q,
  output logic [1:0] mode_out,
  output logic       live
);

  pmode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      PM_NORMAL: begin
        if (!cke) begin
          if (cmd == CMD_REF && !any_open) mode_d = PM_SELF_REF;
          else if (any_open)               mode_d = PM_ACT_PD;
          else                             mode_d = PM_PRE_PD;
        end
      end
      default: begin
        if (cke) mode_d = PM_NORMAL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_NORMAL;
    else        mode_q <= mode_d;
  end

  assign live     = (mode_q == PM_NORMAL) && cke;
  assign mode_out = (mode_q == PM_SELF_REF && cke) ? PM_NORMAL : mode_q;

  // R6: precharge power-down is only ever held with every bank idle
  a_r6_pre_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_PRE_PD) |-> !any_open);

  // R7: self refresh is only ever held with every bank idle
  a_r7_sr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SELF_REF) |-> !any_open);

  // R8: a low-power mode persists while clock enable stays low
  a_r8_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PM_NORMAL && !cke) |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/bktrk_bank_array.sv
module bktrk_bank_array
  import bktrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 live,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic [NUM_BANKS-1:0] open_q,
  output logic                 misuse
);

  logic [NUM_BANKS-1:0] open_d;
  logic                 upd_en;
  logic                 sel_open;

  assign sel_open = open_q[ba];
  assign upd_en   = live && (cmd == CMD_ACT || cmd == CMD_PRE);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(g));

    always_comb begin
      open_d[g] = open_q[g];
      if (cmd == CMD_ACT && hit)          open_d[g] = 1'b1;
      if (cmd == CMD_PRE && (a10 || hit)) open_d[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      open_q[g] <= 1'b0;
      else if (upd_en) open_q[g] <= open_d[g];
    end
  end

  assign misuse = live && ((cmd == CMD_ACT && sel_open) ||
                           ((cmd == CMD_RD || cmd == CMD_WR) && !sel_open));

  // R3: precharge with a10 high leaves no bank open
  a_r3_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cmd == CMD_PRE && a10) |=> (open_q == '0));

  // R2: an accepted activate leaves the addressed bank open
  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cmd == CMD_ACT) |=> open_q[$past(ba)]);

  // R4: access to an idle bank does not change bank state
  a_r4_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (cmd == CMD_RD || cmd == CMD_WR)) |=> $stable(open_q));

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import bktrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic                 cke,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [1:0]           pwr_mode,
  output logic                 mrs_wr,
  output logic                 mrs_sel,
  output logic                 err
);

  cmd_e   cmd;
  pmode_e mode_q;
  logic   live;
  logic   misuse;
  logic   access_drop;
  logic   mrs_go;
  logic   err_d;

  bktrk_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  bktrk_bank_array #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_banks (
    .clk   (clk),
    .rst_n (rst_n),
    .live  (live),
    .cmd   (cmd),
    .ba    (ba),
    .a10   (a10),
    .open_q(bank_open),
    .misuse(misuse)
  );

  bktrk_power_fsm u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cmd     (cmd),
    .any_open(|bank_open),
    .mode_q  (mode_q),
    .mode_out(pwr_mode),
    .live    (live)
  );

  assign access_drop = (mode_q == PM_NORMAL) && !cke &&
                       (cmd == CMD_RD || cmd == CMD_WR);
  assign err_d  = err | misuse | access_drop;
  assign mrs_go = live && (cmd == CMD_MRS) && (ba <= BA_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= 1'b0;
      mrs_wr  <= 1'b0;
      mrs_sel <= 1'b0;
    end else begin
      err    <= err_d;
      mrs_wr <= mrs_go;
      if (mrs_go) mrs_sel <= ba[0];
    end
  end

  // R1: a deselected cycle changes no bank and writes no mode register
  a_r1_cs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(bank_open) && !mrs_wr));

  // R5: a strobe only follows a selected mode-register write
  a_r5_mrs_src: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_wr |-> $past(!cs_n && !ras_n && !cas_n && !we_n));

  // R12: the error flag never clears outside reset
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/ddr_bank_tracker_test.sv
module ddr_bank_tracker_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, ras_n, cas_n, we_n, a10, cke;
  logic [1:0] ba;
  logic [3:0] bank_open;
  logic [1:0] pwr_mode;
  logic       mrs_wr, mrs_sel, err;

  int vectors = 0;
  int miscompares = 0;

  logic [3:0] m_open;
  logic [1:0] m_mode;
  logic       m_err, m_mrs, m_sel;

  always #5 clk = ~clk;

  ddr_bank_tracker uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cke(cke), .bank_open(bank_open),
    .pwr_mode(pwr_mode), .mrs_wr(mrs_wr), .mrs_sel(mrs_sel), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_pwr();
    return (m_mode == 2'd3 && cke) ? 2'd0 : m_mode;
  endfunction

  task automatic compare_all(input string tag);
    chk({tag, " R1/R2/R3 bank_open"}, 32'(bank_open), 32'(m_open));
    chk({tag, " R4/R10/R12 err"}, 32'(err), 32'(m_err));
    chk({tag, " R5 mrs_wr"}, 32'(mrs_wr), 32'(m_mrs));
    chk({tag, " R5 mrs_sel"}, 32'(mrs_sel), 32'(m_sel));
    chk({tag, " R6/R7/R8 pwr_mode"}, 32'(pwr_mode), 32'(exp_pwr()));
  endtask

  // Expected next state, from the requirements
  task automatic model_step();
    logic sel, act, rd, wr, pre, rf, mrs;
    logic [2:0] code;
    sel  = !cs_n;
    code = {ras_n, cas_n, we_n};
    act  = sel && code == 3'b011;
    rd   = sel && code == 3'b101;
    wr   = sel && code == 3'b100;
    pre  = sel && code == 3'b010;
    rf   = sel && code == 3'b001;
    mrs  = sel && code == 3'b000;
    m_mrs = 1'b0;
    if (m_mode == 2'd0) begin
      if (cke) begin
        if (act) begin
          if (m_open[ba]) m_err = 1'b1;
          else            m_open[ba] = 1'b1;
        end
        if ((rd || wr) && !m_open[ba]) m_err = 1'b1;
        if (pre) begin
          if (a10) m_open = 4'b0;
          else     m_open[ba] = 1'b0;
        end
        if (mrs && ba < 2) begin
          m_mrs = 1'b1;
          m_sel = ba[0];
        end
      end else begin
        if (rd || wr) m_err = 1'b1;
        if (rf && m_open == 4'b0) m_mode = 2'd3;
        else if (m_open != 4'b0)  m_mode = 2'd2;
        else                      m_mode = 2'd1;
      end
    end else if (cke) begin
      m_mode = 2'd0;
    end
  endtask

  // v = {cke, a10, ba[1:0], cs_n, ras_n, cas_n, we_n}
  task automatic apply(input logic [7:0] v, input string tag);
    @(negedge clk);
    {cke, a10, ba, cs_n, ras_n, cas_n, we_n} = v;
    #2 chk({tag, " R9 before edge"}, 32'(pwr_mode), 32'(exp_pwr()));
    @(posedge clk);
    model_step();
    #2 compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {cke, a10, ba, cs_n, ras_n, cas_n, we_n} = 8'b1000_0111;
    #2;
    m_open = 4'b0; m_mode = 2'd0; m_err = 1'b0; m_mrs = 1'b0; m_sel = 1'b0;
    compare_all("R11 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] mk(input logic k, input logic a, input logic [1:0] b,
                                    input logic c, input logic [2:0] code);
    return {k, a, b, c, code};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    {cke, a10, ba, cs_n, ras_n, cas_n, we_n} = 8'b1000_0111;
    m_open = 4'b0; m_mode = 2'd0; m_err = 1'b0; m_mrs = 1'b0; m_sel = 1'b0;

    // Directed: R3 single versus all-bank precharge
    do_reset();
    for (int b = 0; b < 4; b++) apply(mk(1, 0, 2'(b), 0, 3'b011), "R2 open");
    apply(mk(1, 0, 2'd2, 0, 3'b010), "R3 single");
    chk("R3 single bank closed", 32'(bank_open), 32'hB);
    apply(mk(1, 1, 2'd0, 0, 3'b010), "R3 all");
    chk("R3 all banks closed", 32'(bank_open), 32'h0);

    // Directed: R12 error persists across later legal traffic
    apply(mk(1, 0, 2'd1, 0, 3'b101), "R4 idle read");
    apply(mk(1, 0, 2'd1, 0, 3'b011), "R12 act");
    apply(mk(1, 0, 2'd1, 0, 3'b111), "R12 nop");
    chk("R12 err held", 32'(err), 32'h1);

    // Directed: R7 then R9 asynchronous self-refresh exit
    do_reset();
    apply(mk(0, 0, 2'd0, 0, 3'b001), "R7 enter");
    chk("R7 self refresh", 32'(pwr_mode), 32'h3);
    @(negedge clk);
    cke = 1'b1;
    #2 chk("R9 early exit", 32'(pwr_mode), 32'h0);
    @(posedge clk); model_step(); #2 compare_all("R9 settle");

    // Exhaustive single-edge sweep over every open-bank pattern
    for (int pat = 0; pat < 16; pat++) begin
      for (int v = 0; v < 256; v++) begin
        do_reset();
        for (int b = 0; b < 4; b++)
          if (pat[b]) apply(mk(1, 0, 2'(b), 0, 3'b011), "R2 setup");
        apply(8'(v), "sweep");
        apply(mk(1, 0, 2'd0, 0, 3'b111), "R8 recover");
      end
    end

    // Pseudo-random multi-step sequences
    for (int n = 0; n < 20000; n++) begin
      logic [7:0] v;
      if (n % 64 == 0) do_reset();
      v = 8'($urandom());
      v[7] = ($urandom() % 8) != 0;
      v[3] = ($urandom() % 6) == 0;
      apply(v, "random");
    end

    finish_run();
  end

endmodule